// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block shifts or rotates one data word. It has no clock. A word, a shift amount and a mode enter together on a valid/ready input. The result leaves on a valid/ready output in the same cycle. The work is done by a chain of 2:1 multiplexer stages, one stage per bit of the shift amount. Stage i moves the word by nothing or by 2^i positions. The shift amount is taken as a binary number from 0 to W-1.

All four modes share one right-shifting chain. Before the chain starts, one fill bit is chosen: a zero, or the sign bit of the input word. Every stage uses that same fill bit. In rotate mode the stages take the bits that leave the low end and wrap them back in at the top. A left shift reverses the bit order of the word before the chain and again after it, so it also runs on the right-shifting chain.

The handshake passes straight through the block. `in_ready` equals `out_ready`, and `out_valid` equals `in_valid`, with no register between them. A word moves on a cycle in which valid and ready are both high. While the consumer holds ready low, the producer must keep the word, amount and mode stable. The result then stays stable as well, because it is computed from those held inputs.

Top module: `bshift_top`

## Requirements
- R1: Mode 2'b00 is a logical left shift by `in_amt`. The vacated low bits are 0.
- R2: Mode 2'b01 is a logical right shift by `in_amt`. The vacated high bits are 0.
- R3: Mode 2'b10 is an arithmetic right shift by `in_amt`. The vacated high bits copy bit W-1 of `in_data`, so the result keeps the sign of the input.
- R4: Mode 2'b11 rotates right by `in_amt`. The bits leaving bit 0 re-enter at bit W-1, so no bit is lost and the count of ones is unchanged.
- R5: An amount of 0 returns `in_data` unchanged in all four modes.
- R6: Every amount from 0 to W-1 is honoured. `in_amt` is clog2(W) bits wide, and the largest amount W-1 gives the result the requirement for that mode defines.
- R7: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. With `in_valid` low, `out_valid` is low.
- R8: An arithmetic right shift of a word whose bit W-1 is 0 gives the same result as a logical right shift.
- R9: While `out_ready` is low and the inputs are held, `in_ready` is low and `out_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Input word, amount and mode are valid |
| in_ready | output | 1 | Block can accept the input; follows out_ready |
| in_data | input | W | Word to shift |
| in_amt | input | clog2(W) | Shift distance, 0 to W-1 |
| in_mode | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| out_valid | output | 1 | Result is valid; follows in_valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | W | Shifted or rotated word |

## Verification
A stalled handshake and a live shift can fall in the same cycle. The bench provokes this by holding `out_ready` low while a valid arithmetic shift is presented. It judges the cycle by two things: `in_ready` must drop, and `out_data` must stay put across the stall. The word is then released and compared against the scoreboard. In a second case, the sign fill and the full-depth stage chain are active together: amount W-1 is applied to a negative word, so every stage both moves data and inserts fill in the same evaluation.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_mode_e;

endpackage

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  logic         wrap,
  input  logic         fill,
  output logic [W-1:0] dout
);

  for (genvar j = 0; j < W; j++) begin : g_bit
    logic pick;
    if (j + DIST < W) begin : g_inside
      assign pick = din[j + DIST];
    end else begin : g_edge
      localparam int WRAP_IDX = j + DIST - W;
      assign pick = wrap ? din[WRAP_IDX] : fill;
    end
    assign dout[j] = en ? pick : din[j];
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [SW-1:0] amt,
  input  shift_mode_e   mode,
  output logic [W-1:0]  result
);

  logic          flip;
  logic          wrap;
  logic          fill;
  logic [W-1:0]  pre;
  logic [W-1:0]  post;
  logic [W-1:0]  lvl [SW+1];

  assign flip = (mode == SH_LSL);
  assign wrap = (mode == SH_ROR);
  assign fill = (mode == SH_ASR) ? data[W-1] : 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_rev
    assign pre[k]    = flip ? data[W-1-k] : data[k];
    assign result[k] = flip ? post[W-1-k] : post[k];
  end

  assign lvl[0] = pre;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    bshift_stage #(
      .W    (W),
      .DIST (1 << s)
    ) u_stage (
      .din  (lvl[s]),
      .en   (amt[s]),
      .wrap (wrap),
      .fill (fill),
      .dout (lvl[s+1])
    );
  end

  assign post = lvl[SW];

endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic [SW-1:0] in_amt,
  input  logic [1:0]    in_mode,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);

  shift_mode_e mode;
  assign mode = shift_mode_e'(in_mode);

  assign in_ready  = out_ready;
  assign out_valid = in_valid;

  bshift_core #(.W(W)) u_core (
    .data   (in_data),
    .amt    (in_amt),
    .mode   (mode),
    .result (out_data)
  );

  always_comb begin
    if (in_valid) begin
      // R5
      amt_zero_identity_chk: assert ((in_amt != '0) || (out_data == in_data));
      // R4
      rotate_popcount_chk: assert ((mode != SH_ROR) ||
                                   ($countones(out_data) == $countones(in_data)));
      // R2
      lsr_top_zero_chk: assert ((mode != SH_LSR) || (in_amt == '0) ||
                                (out_data[W-1] == 1'b0));
      // R1
      lsl_low_zero_chk: assert ((mode != SH_LSL) || (in_amt == '0) ||
                                (out_data[0] == 1'b0));
      // R3
      asr_sign_keep_chk: assert ((mode != SH_ASR) ||
                                 (out_data[W-1] == in_data[W-1]));
    end
  end

endmodule

// File: tb/bshift_top_test.sv
module bshift_top_test;
  localparam int W  = 32;
  localparam int SW = $clog2(W);

  logic          clk = 1'b0;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_data;
  logic [SW-1:0] in_amt;
  logic [1:0]    in_mode;
  logic          out_valid;
  logic          out_ready;
  logic [W-1:0]  out_data;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sb[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always #5 clk = ~clk;

  bshift_top #(.W(W)) uut (
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_amt    (in_amt),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] d,
                                         input logic [SW-1:0] a,
                                         input logic [1:0] m);
    case (m)
      2'b00:   return d << a;
      2'b01:   return d >> a;
      2'b10:   return W'($signed(d) >>> a);
      default: return (a == 0) ? d : ((d >> a) | (d << (W - int'(a))));
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d, input logic [SW-1:0] a,
                      input logic [1:0] m, input logic [W-1:0] exp,
                      input string tag);
    @(posedge clk);
    #1;
    in_valid  = 1'b1;
    in_data   = d;
    in_amt    = a;
    in_mode   = m;
    out_ready = 1'b1;
    sb.push_back('{exp: exp, tag: tag});
  endtask

  // monitor: pops the scoreboard on each accepted result
  always @(negedge clk) begin
    if (!done && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected output", out_data, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(out_data == it.exp, it.tag, out_data, it.exp);
      end
    end
  end

  initial begin
    logic [W-1:0] pats [4];
    int           amts [5];
    string        tg;
    logic [W-1:0] held;
    pats = '{32'h8000_0001, 32'hF0F0_1234, 32'h7FFF_FFFF, 32'hDEAD_BEEF};
    amts = '{0, 1, 4, 13, 31};
    in_valid = 1'b0; in_data = '0; in_amt = '0; in_mode = 2'b00; out_ready = 1'b1;

    // reset state: nothing valid at the output, ready passes through (R7)
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 idle out_valid", W'(out_valid), '0);
    chk(in_ready == 1'b1, "R7 ready follows", W'(in_ready), W'(1));

    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 5; k++) begin
          if (amts[k] == 0)       tg = "R5 zero amount";
          else if (amts[k] == 31) tg = $sformatf("R6 max amount mode %0d", m);
          else if (m == 0)        tg = "R1 left logical";
          else if (m == 1)        tg = "R2 right logical";
          else if (m == 2)        tg = "R3 right arithmetic";
          else                    tg = "R4 rotate right";
          send(pats[p], SW'(amts[k]), 2'(m),
               model(pats[p], SW'(amts[k]), 2'(m)), tg);
        end
      end
    end

    // R8: positive word, arithmetic equals logical
    send(32'h7FFF_FFFF, 5'd9, 2'b10, 32'h7FFF_FFFF >> 9, "R8 asr of positive");
    send(32'h0123_4567, 5'd20, 2'b10, 32'h0123_4567 >> 20, "R8 asr of positive");
    // R3 and R6 together: negative word, full depth, all ones
    send(32'h8000_0000, 5'd31, 2'b10, 32'hFFFF_FFFF, "R3 sign fill full depth");
    // R4 wrap of a single low bit
    send(32'h0000_0001, 5'd1, 2'b11, 32'h8000_0000, "R4 single bit wrap");

    // R9: stall with out_ready low while an arithmetic shift is presented
    @(posedge clk);
    #1;
    in_valid = 1'b1; in_data = 32'h9000_00F0; in_amt = 5'd4; in_mode = 2'b10;
    out_ready = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 in_ready low in stall", W'(in_ready), '0);
    chk(out_valid == 1'b1, "R7 out_valid in stall", W'(out_valid), W'(1));
    held = out_data;
    @(negedge clk);
    chk(out_data == held, "R9 output stable in stall", out_data, held);
    @(posedge clk);
    #1;
    sb.push_back('{exp: 32'hF900_000F, tag: "R9 release after stall"});
    out_ready = 1'b1;

    @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid drop", W'(out_valid), '0);
    chk(sb.size() == 0, "R7 scoreboard drained", W'(sb.size()), '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", n_run);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule